// File: doc/BRIEF.md
# Paired-Page Read Fallback Controller

This controller serves one host page command at a time for a block of two-bit-per-cell flash. It turns a logical page number into a word line, a bit-line parity and a page half (lower or upper bit), and drives a simple array command port. It also maps a word line back to its four page numbers with combinational logic. A read is always sent first as a multi-level read. If a lower-bit page comes back uncorrectable and the word line's upper-page flag shows that the paired upper page was written, the controller reissues the same page once as a single-level read. A single-level read separates the two lowest-and-highest threshold groups, so it can recover lower-bit data that a disturbed multi-level read lost.

A protect command writes an all-ones pattern into the upper page paired with a given lower page. With all ones in the upper half, every cell stays in either the erased state or the highest state. Each cell's bits, written upper then lower, give the threshold states in ascending order as 11, 01, 00, 10. Every command ends with a one-cycle done pulse and a two-bit status. A failure that survives the fallback sets a sticky flag. Reset is the only thing that clears it.

Top module: `pairedPageCtrl`

## Requirements
- R1: Pages 0, 1, 4 and 5 sit on word line 0. For word line k of 1 or more, the pages are 4k-2, 4k-1, 4k+4 and 4k+5. In each case the order is lower-even, lower-odd, upper-even, upper-odd. The issued command shows the page's word line on `arrWl`, its parity on `arrOdd` (1 = odd) and its half on `arrMsb` (1 = upper).
- R2: `mapPages[0..3]` gives the lower-even, lower-odd, upper-even and upper-odd page numbers of the word line on `mapWl`, following the R1 formula, in the same cycle.
- R3: `cmdReady` is high only while the controller is idle. `busy` is high from the cycle after acceptance through the done cycle. `done` is high for exactly one cycle. The cycle after `done`, the controller is idle and ready again.
- R4: Every read first issues a multi-level read (`arrOp` = 0).
- R5: A read whose first response is correctable ends with status 0 (ok). It issues exactly one array command.
- R6: A lower page read may return uncorrectable with `arrRspFlag` = 1. In that case the controller issues one single-level read (`arrOp` = 1) of the same word line and parity. If that read is correctable, the status is 1 (corrected by fallback).
- R7: If the fallback read is also uncorrectable, the status is 2 (fail), `stickyFail` rises and no third command is issued.
- R8: An uncorrectable upper page read ends with status 2 and no retry. So does an uncorrectable lower page read with `arrRspFlag` = 0.
- R9: A protect command (`cmdOp` = 1) on a lower page issues a program-all-ones command (`arrOp` = 2) on the same word line and parity, with `arrMsb` = 1. It ends with status 0 whatever the response verdict.
- R10: A page whose word line is at or beyond `WL_COUNT`, or a protect command aimed at an upper page, ends with status 3 (address error). No array command is issued.
- R11: After reset `cmdReady` is 1 and `busy`, `done` and `stickyFail` are 0. Once set, `stickyFail` stays set through later successful commands.
- R12: While `arrCmdValid` is high and `arrCmdReady` is low, the command stays asserted with unchanged fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Host command request |
| cmdReady | output | 1 | Controller can accept a command |
| cmdOp | input | 1 | 0 = read, 1 = protect paired upper page |
| cmdPage | input | PAGE_W | Logical page number |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| doneStatus | output | 2 | 0 ok, 1 corrected by fallback, 2 fail, 3 address error |
| stickyFail | output | 1 | Set by any fail status, cleared by reset |
| arrCmdValid | output | 1 | Array command request |
| arrCmdReady | input | 1 | Array accepts the command |
| arrOp | output | 2 | 0 multi-level read, 1 single-level read, 2 program all ones |
| arrWl | output | WL_W | Word line |
| arrOdd | output | 1 | Bit-line parity, 1 = odd |
| arrMsb | output | 1 | Page half, 1 = upper |
| arrRspValid | input | 1 | Array response strobe |
| arrRspUncorr | input | 1 | ECC verdict: uncorrectable |
| arrRspFlag | input | 1 | Word-line flag: upper page has been written |
| mapWl | input | WL_W | Word line for reverse lookup |
| mapPages | output | 4 x PAGE_W | Pages of `mapWl`, index 0..3 as in R2 |

## Verification
A wrong decode register would show up on the first issued command as a bad word line, parity or half. A stale retry marker would show up either as a wrong array opcode on the reissued read or as status 1 where 0 was due, within two or three cycles of the response. A state machine stuck outside idle would hold `cmdReady` low past the done pulse, and that is visible the very next cycle. A missed sticky update would show up at the done cycle of the failing command and would stay visible afterwards.

// File: rtl/ppPkg.sv
package ppPkg;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_FIXED = 2'd1,
    ST_FAIL  = 2'd2,
    ST_ADDR  = 2'd3
  } doneCodeT;

  typedef enum logic [1:0] {
    AOP_MLC  = 2'd0,
    AOP_SLC  = 2'd1,
    AOP_PROG = 2'd2
  } arrOpT;

  typedef enum logic [1:0] {
    S_IDLE,
    S_ISSUE,
    S_WAIT,
    S_DONE
  } ctrlStateT;

  typedef struct packed {
    logic     latch;
    logic     retry;
    logic     finish;
    doneCodeT code;
  } ctrlStrobeT;

endpackage

// File: rtl/ppDatapath.sv
module ppDatapath
  import ppPkg::*;
#(
  parameter int WL_COUNT = 64,
  parameter int PAGE_W   = 10,
  parameter int WL_W     = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobeT             strb,
  input  logic                   cmdOp,
  input  logic [PAGE_W-1:0]      cmdPage,
  input  logic [WL_W-1:0]        mapWl,
  output logic                   inBad,
  output logic                   regMsb,
  output logic                   regProt,
  output logic                   retried,
  output logic [1:0]             arrOp,
  output logic [WL_W-1:0]        arrWl,
  output logic                   arrOdd,
  output logic                   arrMsb,
  output logic [1:0]             doneStatus,
  output logic                   stickyFail,
  output logic [3:0][PAGE_W-1:0] mapPages
);

  localparam int EXT = PAGE_W + 1;

  logic [EXT-1:0] pageExt;
  logic           decMsb;
  logic [EXT-1:0] wlFull;
  logic [WL_W-1:0] regWl;
  logic           regOdd;
  doneCodeT       statusReg;
  logic           stickyReg;

  // Page decode: upper pages have bit 1 clear and are 4 or more.
  assign pageExt = {1'b0, cmdPage};
  assign decMsb  = ~cmdPage[1] & (|cmdPage[PAGE_W-1:2]);
  assign wlFull  = decMsb ? ((pageExt >> 2) - EXT'(1)) : ((pageExt + EXT'(2)) >> 2);
  assign inBad   = (wlFull >= EXT'(WL_COUNT)) | (cmdOp & decMsb);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regWl     <= '0;
      regOdd    <= 1'b0;
      regMsb    <= 1'b0;
      regProt   <= 1'b0;
      retried   <= 1'b0;
      statusReg <= ST_OK;
      stickyReg <= 1'b0;
    end else begin
      if (strb.latch) begin
        regWl   <= wlFull[WL_W-1:0];
        regOdd  <= cmdPage[0];
        regMsb  <= decMsb;
        regProt <= cmdOp;
        retried <= 1'b0;
      end
      if (strb.retry) retried <= 1'b1;
      if (strb.finish) begin
        statusReg <= strb.code;
        if (strb.code == ST_FAIL) stickyReg <= 1'b1;
      end
    end
  end

  always_comb begin
    if (regProt)      arrOp = AOP_PROG;
    else if (retried) arrOp = AOP_SLC;
    else              arrOp = AOP_MLC;
  end

  assign arrWl      = regWl;
  assign arrOdd     = regOdd;
  assign arrMsb     = regMsb | regProt;
  assign doneStatus = statusReg;
  assign stickyFail = stickyReg;

  // Reverse lookup: one adder per page slot.
  for (genvar i = 0; i < 4; i++) begin : g_map
    localparam int LOW = (i < 2) ? i : i + 2;
    localparam int OFS = (i < 2) ? i - 2 : i + 2;
    logic [PAGE_W-1:0] base;
    assign base        = PAGE_W'({mapWl, 2'b00});
    assign mapPages[i] = (mapWl == '0) ? PAGE_W'(LOW) : base + PAGE_W'(OFS);
  end

  // R11
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stickyFail |=> stickyFail);

endmodule

// File: rtl/ppControl.sv
module ppControl
  import ppPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  output logic       cmdReady,
  output logic       busy,
  output logic       done,
  input  logic       inBad,
  input  logic       regMsb,
  input  logic       regProt,
  input  logic       retried,
  output logic       arrCmdValid,
  input  logic       arrCmdReady,
  input  logic       arrRspValid,
  input  logic       arrRspUncorr,
  input  logic       arrRspFlag,
  output ctrlStrobeT strb
);

  ctrlStateT state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    strb.code = ST_OK;
    unique case (state)
      S_IDLE: begin
        if (cmdValid) begin
          strb.latch = 1'b1;
          if (inBad) begin
            strb.finish = 1'b1;
            strb.code   = ST_ADDR;
            nextState   = S_DONE;
          end else begin
            nextState = S_ISSUE;
          end
        end
      end
      S_ISSUE: begin
        if (arrCmdReady) nextState = S_WAIT;
      end
      S_WAIT: begin
        if (arrRspValid) begin
          if (regProt) begin
            strb.finish = 1'b1;
            strb.code   = ST_OK;
            nextState   = S_DONE;
          end else if (!arrRspUncorr) begin
            strb.finish = 1'b1;
            strb.code   = retried ? ST_FIXED : ST_OK;
            nextState   = S_DONE;
          end else if (!regMsb && arrRspFlag && !retried) begin
            strb.retry = 1'b1;
            nextState  = S_ISSUE;
          end else begin
            strb.finish = 1'b1;
            strb.code   = ST_FAIL;
            nextState   = S_DONE;
          end
        end
      end
      S_DONE: nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign cmdReady    = (state == S_IDLE);
  assign busy        = (state != S_IDLE);
  assign done        = (state == S_DONE);
  assign arrCmdValid = (state == S_ISSUE);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> busy);

  // R12
  issue_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (arrCmdValid && !arrCmdReady) |=> arrCmdValid);

  // R10
  bad_no_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady && inBad) |=> (!arrCmdValid && done));

endmodule

// File: rtl/pairedPageCtrl.sv
module pairedPageCtrl
  import ppPkg::*;
#(
  parameter int WL_COUNT = 64,
  parameter int PAGE_W   = $clog2(4 * WL_COUNT + 2) + 1,
  localparam int WL_W    = $clog2(WL_COUNT)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cmdValid,
  output logic                   cmdReady,
  input  logic                   cmdOp,
  input  logic [PAGE_W-1:0]      cmdPage,
  output logic                   busy,
  output logic                   done,
  output logic [1:0]             doneStatus,
  output logic                   stickyFail,
  output logic                   arrCmdValid,
  input  logic                   arrCmdReady,
  output logic [1:0]             arrOp,
  output logic [WL_W-1:0]        arrWl,
  output logic                   arrOdd,
  output logic                   arrMsb,
  input  logic                   arrRspValid,
  input  logic                   arrRspUncorr,
  input  logic                   arrRspFlag,
  input  logic [WL_W-1:0]        mapWl,
  output logic [3:0][PAGE_W-1:0] mapPages
);

  ctrlStrobeT strb;
  logic inBad, regMsb, regProt, retried;

  ppControl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cmdValid     (cmdValid),
    .cmdReady     (cmdReady),
    .busy         (busy),
    .done         (done),
    .inBad        (inBad),
    .regMsb       (regMsb),
    .regProt      (regProt),
    .retried      (retried),
    .arrCmdValid  (arrCmdValid),
    .arrCmdReady  (arrCmdReady),
    .arrRspValid  (arrRspValid),
    .arrRspUncorr (arrRspUncorr),
    .arrRspFlag   (arrRspFlag),
    .strb         (strb)
  );

  ppDatapath #(
    .WL_COUNT (WL_COUNT),
    .PAGE_W   (PAGE_W),
    .WL_W     (WL_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cmdOp      (cmdOp),
    .cmdPage    (cmdPage),
    .mapWl      (mapWl),
    .inBad      (inBad),
    .regMsb     (regMsb),
    .regProt    (regProt),
    .retried    (retried),
    .arrOp      (arrOp),
    .arrWl      (arrWl),
    .arrOdd     (arrOdd),
    .arrMsb     (arrMsb),
    .doneStatus (doneStatus),
    .stickyFail (stickyFail),
    .mapPages   (mapPages)
  );

  // R7
  fail_sets_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && doneStatus == 2'd2) |-> stickyFail);

  // R12
  issue_fields_chk: assert property (@(posedge clk) disable iff (!rstN)
    (arrCmdValid && !arrCmdReady) |=> ($stable(arrWl) && $stable(arrOdd) && $stable(arrOp)));

endmodule

// File: tb/sim_pairedPageCtrl.sv
`timescale 1ns/1ps
module sim_pairedPageCtrl;

  localparam int N  = 64;
  localparam int PW = 10;
  localparam int WW = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0, cmdOp = 1'b0;
  logic [PW-1:0] cmdPage = '0;
  logic cmdReady, busy, done, stickyFail, arrCmdValid, arrOdd, arrMsb;
  logic [1:0] doneStatus, arrOp;
  logic [WW-1:0] arrWl;
  logic arrCmdReady = 1'b0, arrRspValid = 1'b0, arrRspUncorr = 1'b0, arrRspFlag = 1'b0;
  logic [WW-1:0] mapWl = '0;
  logic [3:0][PW-1:0] mapPages;

  int checks = 0, fails = 0, cycles = 0;

  int nIss, gotStatus;
  int recOp[4], recWl[4], recOdd[4], recMsb[4];
  bit busyOk, stableOk;

  always #4 clk = ~clk;

  pairedPageCtrl #(.WL_COUNT(N), .PAGE_W(PW)) u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOp(cmdOp),
    .cmdPage(cmdPage), .busy(busy), .done(done), .doneStatus(doneStatus),
    .stickyFail(stickyFail), .arrCmdValid(arrCmdValid), .arrCmdReady(arrCmdReady),
    .arrOp(arrOp), .arrWl(arrWl), .arrOdd(arrOdd), .arrMsb(arrMsb),
    .arrRspValid(arrRspValid), .arrRspUncorr(arrRspUncorr), .arrRspFlag(arrRspFlag),
    .mapWl(mapWl), .mapPages(mapPages)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int pageOf(input int k, input int i);
    if (k == 0) return (i < 2) ? i : i + 2;
    return (i < 2) ? 4 * k - 2 + i : 4 * k + 2 + i;
  endfunction

  // Issue one command, play the array, collect what was issued.
  task automatic runCmd(input logic op, input int page, input logic u1, input logic f1,
                        input logic u2, input logic f2, input int stall);
    bit inCmd = 0, respondNow = 0, gotDone = 0;
    int stallLeft = 0;
    nIss = 0; gotStatus = -1; busyOk = 1; stableOk = 1;
    @(negedge clk);
    chk(cmdReady == 1'b1, "R3", "ready when idle", int'(cmdReady), 1);
    cmdValid = 1'b1; cmdOp = op; cmdPage = PW'(page);
    for (int cyc = 0; cyc < 60; cyc++) begin
      @(negedge clk);
      if (cyc == 0) cmdValid = 1'b0;
      arrRspValid = 1'b0; arrCmdReady = 1'b0;
      if (respondNow) begin
        arrRspValid  = 1'b1;
        arrRspUncorr = (nIss == 1) ? u1 : u2;
        arrRspFlag   = (nIss == 1) ? f1 : f2;
        respondNow   = 0;
      end
      if (busy !== 1'b1 || cmdReady !== 1'b0) busyOk = 0;
      if (done) begin
        gotStatus = int'(doneStatus);
        gotDone = 1;
        break;
      end
      if (arrCmdValid && nIss < 4) begin
        if (!inCmd) begin
          inCmd = 1; stallLeft = stall;
          recOp[nIss] = int'(arrOp); recWl[nIss] = int'(arrWl);
          recOdd[nIss] = int'(arrOdd); recMsb[nIss] = int'(arrMsb);
        end else if (recOp[nIss] != int'(arrOp) || recWl[nIss] != int'(arrWl) ||
                     recOdd[nIss] != int'(arrOdd)) begin
          stableOk = 0;
        end
        if (stallLeft > 0) stallLeft--;
        else begin
          arrCmdReady = 1'b1; inCmd = 0; nIss++; respondNow = 1;
        end
      end
    end
    chk(gotDone, "R3", "done seen", int'(gotDone), 1);
    chk(busyOk, "R3", "busy high and ready low while working", int'(busyOk), 1);
    @(negedge clk);
    arrRspValid = 1'b0;
    chk(!done && !busy && cmdReady, "R3", "idle after done pulse",
        {done, busy, cmdReady}, 3'b001);
  endtask

  task automatic testReset;
    @(negedge clk);
    chk(cmdReady == 1 && busy == 0 && done == 0 && stickyFail == 0, "R11", "reset state",
        {cmdReady, busy, done, stickyFail}, 4'b1000);
  endtask

  task automatic testForwardMap;
    for (int k = 0; k < N; k++) begin
      for (int i = 0; i < 4; i++) begin
        int pg = pageOf(k, i);
        runCmd(1'b0, pg, 1'b0, 1'b1, 1'b0, 1'b1, 0);
        chk(recWl[0] == k && recOdd[0] == (i % 2) && recMsb[0] == (i >= 2), "R1",
            $sformatf("fields page %0d", pg), recWl[0] * 4 + recOdd[0] * 2 + recMsb[0],
            k * 4 + (i % 2) * 2 + (i >= 2 ? 1 : 0));
        chk(recOp[0] == 0, "R4", "first read multi-level", recOp[0], 0);
        chk(nIss == 1 && gotStatus == 0, "R5", "one command, ok", nIss * 10 + gotStatus, 10);
      end
    end
    chk(stickyFail == 0, "R11", "sticky clear after clean reads", int'(stickyFail), 0);
  endtask

  task automatic testReverseMap;
    int wls[4] = '{0, 1, 2, N - 1};
    foreach (wls[j]) begin
      @(negedge clk);
      mapWl = WW'(wls[j]);
      #1;
      for (int i = 0; i < 4; i++)
        chk(int'(mapPages[i]) == pageOf(wls[j], i), "R2",
            $sformatf("wl %0d slot %0d", wls[j], i), int'(mapPages[i]), pageOf(wls[j], i));
    end
  endtask

  task automatic testFallbackRecovers;
    runCmd(1'b0, 6, 1'b1, 1'b1, 1'b0, 1'b1, 2);
    chk(nIss == 2, "R6", "two commands", nIss, 2);
    chk(recOp[0] == 0 && recOp[1] == 1, "R6", "ops multi then single",
        recOp[0] * 10 + recOp[1], 1);
    chk(recWl[1] == 2 && recOdd[1] == 0 && recMsb[1] == 0, "R6", "retry same page",
        recWl[1] * 4 + recOdd[1] * 2 + recMsb[1], 8);
    chk(gotStatus == 1, "R6", "corrected by fallback", gotStatus, 1);
    chk(stableOk, "R12", "command held while stalled", int'(stableOk), 1);
    chk(stickyFail == 0, "R11", "no sticky on recovery", int'(stickyFail), 0);
  endtask

  task automatic testNoRetryCases;
    runCmd(1'b0, 9, 1'b1, 1'b1, 1'b0, 1'b1, 0);
    chk(nIss == 1 && gotStatus == 2, "R8", "upper page uncorrectable", nIss * 10 + gotStatus, 12);
    chk(stickyFail == 1, "R7", "sticky after fail", int'(stickyFail), 1);
    runCmd(1'b0, 3, 1'b1, 1'b0, 1'b0, 1'b1, 0);
    chk(nIss == 1 && gotStatus == 2, "R8", "lower page with flag clear", nIss * 10 + gotStatus, 12);
  endtask

  task automatic testDoubleFail;
    runCmd(1'b0, 1, 1'b1, 1'b1, 1'b1, 1'b1, 1);
    chk(nIss == 2, "R7", "exactly one retry", nIss, 2);
    chk(gotStatus == 2, "R7", "fail status", gotStatus, 2);
    chk(stickyFail == 1, "R7", "sticky set", int'(stickyFail), 1);
    runCmd(1'b0, 2, 1'b0, 1'b1, 1'b0, 1'b1, 0);
    chk(gotStatus == 0 && stickyFail == 1, "R11", "sticky survives ok read",
        gotStatus * 10 + int'(stickyFail), 1);
  endtask

  task automatic testProtect;
    runCmd(1'b1, 6, 1'b1, 1'b0, 1'b1, 1'b0, 0);
    chk(nIss == 1 && recOp[0] == 2, "R9", "program-ones issued", nIss * 10 + recOp[0], 12);
    chk(recWl[0] == 2 && recOdd[0] == 0 && recMsb[0] == 1, "R9", "paired upper page",
        recWl[0] * 4 + recOdd[0] * 2 + recMsb[0], 9);
    chk(gotStatus == 0, "R9", "verdict ignored", gotStatus, 0);
    runCmd(1'b1, 1, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    chk(recWl[0] == 0 && recOdd[0] == 1 && recMsb[0] == 1 && gotStatus == 0, "R9",
        "protect on word line 0", recWl[0] * 4 + recOdd[0] * 2 + recMsb[0], 3);
  endtask

  task automatic testAddrErr;
    int bad[4] = '{4 * N + 2, 4 * N + 3, 4 * N + 4, 1000};
    foreach (bad[j]) begin
      runCmd(1'b0, bad[j], 1'b0, 1'b1, 1'b0, 1'b1, 0);
      chk(nIss == 0 && gotStatus == 3, "R10", $sformatf("page %0d rejected", bad[j]),
          nIss * 10 + gotStatus, 3);
    end
    runCmd(1'b1, 9, 1'b0, 1'b1, 1'b0, 1'b1, 0);
    chk(nIss == 0 && gotStatus == 3, "R10", "protect on upper page", nIss * 10 + gotStatus, 3);
    runCmd(1'b0, 4 * N + 1, 1'b0, 1'b1, 1'b0, 1'b1, 0);
    chk(nIss == 1 && recWl[0] == N - 1 && gotStatus == 0, "R10", "last page accepted",
        recWl[0], N - 1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    testReset();
    testForwardMap();
    testReverseMap();
    testFallbackRecovers();
    testNoRetryCases();
    testDoubleFail();
    testProtect();
    testAddrErr();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule